// File: doc/BRIEF.md
# Pipelined Set-Associative L1 Data Cache

This block is a level-1 data cache placed between a processor pipeline and a lower memory level that moves whole lines. It is set-associative, write-back and write-allocate. The number of sets, the words per line and the number of ways are parameters. A parameter also selects the replacement policy: true least-recently-used or pseudo-random.

The processor side takes a word address, write data and four strobes: read, write, flush and invalidate. It returns a data word, the address that word belongs to, a valid flag and a ready flag. The cache is pipelined. A request accepted on one clock edge returns its result in the next cycle. While that result is on the outputs, ready stays high, so a second request can be accepted in the same cycle and two are in flight. On a miss or a dirty flush, ready and valid both drop until the lower level has answered. The request is then completed in place.

The lower side carries a full line, a line-aligned address and a 4-bit message code. Each message is held until the lower level answers it with a one-cycle response code.

Top module: `l1c_top`

## Requirements
- R1: A read or write hit accepted on a clock edge (strobe high while `cpu_ready_o` is high) gives `cpu_valid_o` high in the very next cycle. `cpu_addr_o` echoes the request address. A read returns the stored word; a write returns its own write data.
- R2: While hits complete, `cpu_ready_o` stays high. A request presented in the cycle a previous result is returned is accepted, and its result follows one cycle later.
- R3: On a read or write miss, `cpu_ready_o` and `cpu_valid_o` stay low. The cache drives message 1 (line read) with a line-aligned address, meaning the low OFFSET_BITS bits are zero. The lower level answers with message 8 and the line on `mem_line_i`. The request then completes from the filled line. Address bits [OFFSET_BITS-1:0] select the word in the line, the next INDEX_BITS bits select the set, and the rest form the tag. Word k of a line sits at bits [k*DATA_W +: DATA_W].
- R4: A write hit updates only the cached line and marks it dirty, with no lower-level message. A write miss first fetches the line, then merges the word.
- R5: When the chosen victim is dirty, the cache first sends message 2 (write-back) with the victim line and its address. It waits for response 9 (acknowledge) and only then issues the line read.
- R6: A flush of a dirty line sends message 3 with the line and its address. After response 9 the line is removed and the flush completes with `cpu_valid_o`. A flush of a clean or absent line completes one cycle after acceptance with no lower-level message, and any clean copy is removed.
- R7: Invalidate removes the line holding the address without any write-back, so dirty data in it is discarded. It completes one cycle after acceptance with no lower-level message.
- R8: A fill goes to an invalid way of the set when one exists. Otherwise, in LRU mode the least recently used way is evicted, where both hits and fills count as uses. In random mode a free-running LFSR picks the way.
- R9: When several strobes are high together, only one operation is performed, chosen in the priority order flush, invalidate, write, read.
- R10: After reset, `cpu_ready_o` is high, `cpu_valid_o` is low, `mem_msg_o` is 0, and every line is invalid.
- R11: A nonzero `mem_msg_o` keeps its value, together with its address and line, until a response arrives on `mem_msg_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr_i | input | ADDR_W | Request word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rd_i | input | 1 | Read strobe |
| cpu_wr_i | input | 1 | Write strobe |
| cpu_flush_i | input | 1 | Flush-line strobe |
| cpu_inv_i | input | 1 | Invalidate-line strobe |
| cpu_rdata_o | output | DATA_W | Returned word |
| cpu_addr_o | output | ADDR_W | Address of the returned word |
| cpu_valid_o | output | 1 | Result valid this cycle |
| cpu_ready_o | output | 1 | A request presented now is accepted |
| mem_line_o | output | DATA_W*2^OFFSET_BITS | Line sent with write-back and flush |
| mem_addr_o | output | ADDR_W | Line-aligned address of the message |
| mem_msg_o | output | 4 | Request code: 0 none, 1 read, 2 write-back, 3 flush |
| mem_line_i | input | DATA_W*2^OFFSET_BITS | Line returned for a read |
| mem_msg_i | input | 4 | Response code: 8 line data, 9 acknowledge, else none |

## Verification
The checker enforces several rules on every cycle: requests to the lower level hold steady until answered, the processor side is stalled while a message is outstanding, every message address is line-aligned, and an acknowledged write-back is followed directly by the line read. It also checks that an acknowledged flush frees the lower interface. Hit latency, returned data, the choice of LRU victim, data surviving an eviction, the loss of dirty data on invalidate and strobe priority are shown only by the bench scenarios. The bench runs a write, eviction and read-back sequence against its own memory model and records the message log.

// File: rtl/l1c_pkg.sv
package l1c_pkg;

    typedef enum logic [1:0] {OP_RD, OP_WR, OP_FL, OP_INV} op_t;
    typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_RD, ST_FL} st_t;

    localparam logic [3:0] MSG_NONE = 4'h0;
    localparam logic [3:0] MSG_RD   = 4'h1;
    localparam logic [3:0] MSG_WB   = 4'h2;
    localparam logic [3:0] MSG_FL   = 4'h3;
    localparam logic [3:0] MSG_DATA = 4'h8;
    localparam logic [3:0] MSG_ACK  = 4'h9;

    function automatic int sel_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // flush > invalidate > write > read
    function automatic op_t pick_op(logic rd, logic wr, logic fl, logic inv);
        if (fl)       return OP_FL;
        else if (inv) return OP_INV;
        else if (wr)  return OP_WR;
        else          return OP_RD;
    endfunction

endpackage

// File: rtl/l1c_store.sv
module l1c_store #(
    parameter int TAG_W  = 9,
    parameter int LINE_W = 64,
    parameter int DATA_W = 32,
    parameter int INDEX_BITS = 2,
    parameter int OFFSET_BITS = 1,
    parameter int WAYS = 2,
    parameter int WAY_W = 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [INDEX_BITS-1:0]             rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]        tags_o,
    output logic [WAYS-1:0]                   vld_o,
    output logic [WAYS-1:0]                   dirty_o,
    output logic [WAYS-1:0][LINE_W-1:0]       lines_o,
    input  logic                              word_en,
    input  logic                              fill_en,
    input  logic                              kill_en,
    input  logic [WAY_W-1:0]                  w_way,
    input  logic [INDEX_BITS-1:0]             w_set,
    input  logic [OFFSET_BITS-1:0]            w_off,
    input  logic [DATA_W-1:0]                 w_word,
    input  logic [TAG_W-1:0]                  f_tag,
    input  logic [LINE_W-1:0]                 f_line
);
    localparam int SETS = 1 << INDEX_BITS;

    // one storage array per way
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0]  tag_m [SETS];
        logic [LINE_W-1:0] dat_m [SETS];
        logic [SETS-1:0]   v_m, d_m;
        logic              sel;

        assign sel = (w_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_m <= '0;
                d_m <= '0;
            end else if (sel) begin
                if (fill_en) begin
                    v_m[w_set] <= 1'b1;
                    d_m[w_set] <= 1'b0;
                end else if (kill_en) begin
                    v_m[w_set] <= 1'b0;
                    d_m[w_set] <= 1'b0;
                end else if (word_en) begin
                    d_m[w_set] <= 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (sel && fill_en) begin
                tag_m[w_set] <= f_tag;
                dat_m[w_set] <= f_line;
            end else if (sel && word_en) begin
                dat_m[w_set][w_off*DATA_W +: DATA_W] <= w_word;
            end
        end

        assign tags_o[w]  = tag_m[rd_set];
        assign lines_o[w] = dat_m[rd_set];
        assign vld_o[w]   = v_m[rd_set];
        assign dirty_o[w] = d_m[rd_set];
    end

endmodule

// File: rtl/l1c_repl.sv
module l1c_repl #(
    parameter int  INDEX_BITS = 2,
    parameter int  WAYS = 2,
    parameter int  WAY_W = 1,
    parameter bit  USE_RANDOM = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [INDEX_BITS-1:0] look_set,
    input  logic [WAYS-1:0]       vld_vec,
    input  logic                  touch_en,
    input  logic [INDEX_BITS-1:0] touch_set,
    input  logic [WAY_W-1:0]      touch_way,
    output logic [WAY_W-1:0]      victim_o
);
    localparam int SETS = 1 << INDEX_BITS;

    logic [WAY_W-1:0] base_way;

    if (USE_RANDOM) begin : g_rand
        logic [15:0] lfsr;
        logic        unused_touch;
        assign unused_touch = ^{touch_en, touch_set, touch_way, look_set};

        always_ff @(posedge clk) begin
            if (rst) lfsr <= 16'hACE1;
            else     lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        assign base_way = WAY_W'(int'(lfsr) % WAYS);
    end else begin : g_lru
        // age 0 = most recent, WAYS-1 = least recent; ages form a permutation per set
        logic [WAY_W-1:0] age [SETS][WAYS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        age[s][w] <= WAY_W'(w);
            end else if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        age[touch_set][w] <= '0;
                    else if (age[touch_set][w] < age[touch_set][touch_way])
                        age[touch_set][w] <= age[touch_set][w] + 1'b1;
                end
            end
        end

        always_comb begin
            base_way = '0;
            for (int w = 0; w < WAYS; w++)
                if (age[look_set][w] == WAY_W'(WAYS - 1)) base_way = WAY_W'(w);
        end
    end

    // an invalid way always wins, lowest index first
    always_comb begin
        victim_o = base_way;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!vld_vec[w]) victim_o = WAY_W'(w);
    end

endmodule

// File: rtl/l1c_top.sv
module l1c_top
    import l1c_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int INDEX_BITS  = 2,
    parameter int OFFSET_BITS = 1,
    parameter int WAYS        = 2,
    parameter bit USE_RANDOM  = 1'b0
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [ADDR_W-1:0]                     cpu_addr_i,
    input  logic [DATA_W-1:0]                     cpu_wdata_i,
    input  logic                                  cpu_rd_i,
    input  logic                                  cpu_wr_i,
    input  logic                                  cpu_flush_i,
    input  logic                                  cpu_inv_i,
    output logic [DATA_W-1:0]                     cpu_rdata_o,
    output logic [ADDR_W-1:0]                     cpu_addr_o,
    output logic                                  cpu_valid_o,
    output logic                                  cpu_ready_o,
    output logic [DATA_W*(1<<OFFSET_BITS)-1:0]    mem_line_o,
    output logic [ADDR_W-1:0]                     mem_addr_o,
    output logic [3:0]                            mem_msg_o,
    input  logic [DATA_W*(1<<OFFSET_BITS)-1:0]    mem_line_i,
    input  logic [3:0]                            mem_msg_i
);
    localparam int WPL    = 1 << OFFSET_BITS;
    localparam int LINE_W = DATA_W * WPL;
    localparam int TAG_W  = ADDR_W - INDEX_BITS - OFFSET_BITS;
    localparam int WAY_W  = sel_w(WAYS);

    st_t                 state;
    logic                p_vld;
    op_t                 p_op;
    logic [ADDR_W-1:0]   p_addr;
    logic [DATA_W-1:0]   p_wdata;
    logic [WAY_W-1:0]    vict_q;

    logic [INDEX_BITS-1:0]  p_set;
    logic [TAG_W-1:0]       p_tag;
    logic [OFFSET_BITS-1:0] p_off;
    assign p_off = p_addr[OFFSET_BITS-1:0];
    assign p_set = p_addr[OFFSET_BITS +: INDEX_BITS];
    assign p_tag = p_addr[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0][TAG_W-1:0]  tags;
    logic [WAYS-1:0][LINE_W-1:0] lines;
    logic [WAYS-1:0]             vlds, dirts, hit_vec;
    logic                        hit, is_acc, need_fetch, need_fl, stall;
    logic [WAY_W-1:0]            hit_way, victim, w_way;
    logic                        word_en, fill_en, kill_en, touch_en;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = vlds[w] && (tags[w] == p_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit        = |hit_vec;
    assign is_acc     = (p_op == OP_RD) || (p_op == OP_WR);
    assign need_fetch = p_vld && is_acc && !hit;
    assign need_fl    = p_vld && (p_op == OP_FL) && hit && dirts[hit_way];
    assign stall      = need_fetch || need_fl;

    assign cpu_ready_o = (state == ST_IDLE) && !stall;
    assign cpu_valid_o = (state == ST_IDLE) && p_vld && !stall;
    assign cpu_addr_o  = p_addr;
    assign cpu_rdata_o = (p_op == OP_WR) ? p_wdata
                                         : lines[hit_way][p_off*DATA_W +: DATA_W];

    assign fill_en  = (state == ST_RD) && (mem_msg_i == MSG_DATA);
    assign word_en  = (state == ST_IDLE) && p_vld && (p_op == OP_WR) && hit;
    assign kill_en  = ((state == ST_IDLE) && p_vld && hit &&
                       ((p_op == OP_INV) || ((p_op == OP_FL) && !dirts[hit_way]))) ||
                      ((state == ST_FL) && (mem_msg_i == MSG_ACK));
    assign touch_en = fill_en || ((state == ST_IDLE) && p_vld && is_acc && hit);
    assign w_way    = fill_en ? vict_q : hit_way;

    l1c_store #(
        .TAG_W(TAG_W), .LINE_W(LINE_W), .DATA_W(DATA_W), .INDEX_BITS(INDEX_BITS),
        .OFFSET_BITS(OFFSET_BITS), .WAYS(WAYS), .WAY_W(WAY_W)
    ) u_store (
        .clk(clk), .rst(rst), .rd_set(p_set),
        .tags_o(tags), .vld_o(vlds), .dirty_o(dirts), .lines_o(lines),
        .word_en(word_en), .fill_en(fill_en), .kill_en(kill_en),
        .w_way(w_way), .w_set(p_set), .w_off(p_off), .w_word(p_wdata),
        .f_tag(p_tag), .f_line(mem_line_i)
    );

    l1c_repl #(
        .INDEX_BITS(INDEX_BITS), .WAYS(WAYS), .WAY_W(WAY_W), .USE_RANDOM(USE_RANDOM)
    ) u_repl (
        .clk(clk), .rst(rst), .look_set(p_set), .vld_vec(vlds),
        .touch_en(touch_en), .touch_set(p_set), .touch_way(w_way),
        .victim_o(victim)
    );

    always_comb begin
        mem_msg_o  = MSG_NONE;
        mem_addr_o = '0;
        mem_line_o = '0;
        case (state)
            ST_WB: begin
                mem_msg_o  = MSG_WB;
                mem_addr_o = {tags[vict_q], p_set, {OFFSET_BITS{1'b0}}};
                mem_line_o = lines[vict_q];
            end
            ST_RD: begin
                mem_msg_o  = MSG_RD;
                mem_addr_o = {p_tag, p_set, {OFFSET_BITS{1'b0}}};
            end
            ST_FL: begin
                mem_msg_o  = MSG_FL;
                mem_addr_o = {p_tag, p_set, {OFFSET_BITS{1'b0}}};
                mem_line_o = lines[hit_way];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            p_vld <= 1'b0;
            vict_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (need_fetch) begin
                        vict_q <= victim;
                        state  <= (vlds[victim] && dirts[victim]) ? ST_WB : ST_RD;
                    end else if (need_fl) begin
                        state <= ST_FL;
                    end
                end
                ST_WB: if (mem_msg_i == MSG_ACK)  state <= ST_RD;
                ST_RD: if (mem_msg_i == MSG_DATA) state <= ST_IDLE;
                ST_FL: if (mem_msg_i == MSG_ACK)  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
            if (cpu_ready_o)
                p_vld <= cpu_rd_i | cpu_wr_i | cpu_flush_i | cpu_inv_i;
        end
    end

    always_ff @(posedge clk) begin
        if (cpu_ready_o) begin
            p_op    <= pick_op(cpu_rd_i, cpu_wr_i, cpu_flush_i, cpu_inv_i);
            p_addr  <= cpu_addr_i;
            p_wdata <= cpu_wdata_i;
        end
    end

endmodule

// File: rtl/l1c_top_chk.sv
module l1c_top_chk
    import l1c_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int OFFSET_BITS = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid_o,
    input logic              cpu_ready_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [3:0]        mem_msg_o,
    input logic [3:0]        mem_msg_i
);
    // R11
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_msg_o != MSG_NONE && mem_msg_i == MSG_NONE) |=> (mem_msg_o == $past(mem_msg_o)));

    // R3
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_msg_o != MSG_NONE) |-> (!cpu_valid_o && !cpu_ready_o));

    // R3
    line_align_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_msg_o != MSG_NONE) |-> (mem_addr_o[OFFSET_BITS-1:0] == '0));

    // R5
    wb_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_msg_o == MSG_WB && mem_msg_i == MSG_ACK) |=> (mem_msg_o == MSG_RD));

    // R6
    flush_done_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_msg_o == MSG_FL && mem_msg_i == MSG_ACK) |=> (mem_msg_o == MSG_NONE));

endmodule

bind l1c_top l1c_top_chk #(.ADDR_W(ADDR_W), .OFFSET_BITS(OFFSET_BITS)) u_chk (
    .clk(clk), .rst(rst), .cpu_valid_o(cpu_valid_o), .cpu_ready_o(cpu_ready_o),
    .mem_addr_o(mem_addr_o), .mem_msg_o(mem_msg_o), .mem_msg_i(mem_msg_i)
);

// File: tb/l1c_top_test.sv
module l1c_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cpu_addr_i = '0;
    logic [31:0] cpu_wdata_i = '0;
    logic        cpu_rd_i = 1'b0, cpu_wr_i = 1'b0, cpu_flush_i = 1'b0, cpu_inv_i = 1'b0;
    logic [31:0] cpu_rdata_o;
    logic [11:0] cpu_addr_o;
    logic        cpu_valid_o, cpu_ready_o;
    logic [63:0] mem_line_o, mem_line_i = '0;
    logic [11:0] mem_addr_o;
    logic [3:0]  mem_msg_o, mem_msg_i = 4'h0;

    always #5 clk = ~clk;

    l1c_top uut (
        .clk(clk), .rst(rst), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
        .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i), .cpu_flush_i(cpu_flush_i),
        .cpu_inv_i(cpu_inv_i), .cpu_rdata_o(cpu_rdata_o), .cpu_addr_o(cpu_addr_o),
        .cpu_valid_o(cpu_valid_o), .cpu_ready_o(cpu_ready_o), .mem_line_o(mem_line_o),
        .mem_addr_o(mem_addr_o), .mem_msg_o(mem_msg_o), .mem_line_i(mem_line_i),
        .mem_msg_i(mem_msg_i)
    );

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // lower-level memory model and message log
    logic [31:0] mem [4096];
    logic [3:0]  msg_log [64];
    int          log_n = 0;
    logic [11:0] last_wb_addr = '0, last_rd_addr = '0;
    logic [63:0] last_wb_line = '0;

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'hA000_0000 | i;
        forever begin
            @(negedge clk);
            if (!rst && mem_msg_o != 4'h0) begin
                logic [3:0]  m;
                logic [11:0] a;
                m = mem_msg_o;
                a = mem_addr_o;
                if (log_n < 64) msg_log[log_n] = m;
                log_n++;
                @(negedge clk);
                check(mem_msg_o == m && mem_addr_o == a, "R11", "message held",
                      {28'h0, mem_msg_o}, {28'h0, m});
                if (m == 4'h1) begin
                    last_rd_addr = a;
                    mem_line_i = {mem[a + 12'd1], mem[a]};
                    mem_msg_i = 4'h8;
                end else begin
                    last_wb_addr = a;
                    last_wb_line = mem_line_o;
                    mem[a] = mem_line_o[31:0];
                    mem[a + 12'd1] = mem_line_o[63:32];
                    mem_msg_i = 4'h9;
                end
                @(negedge clk);
                mem_msg_i = 4'h0;
            end
        end
    end

    // op: 0 read, 1 write, 2 flush, 3 invalidate
    task automatic drive(input logic [1:0] op, input logic [11:0] a, input logic [31:0] wd);
        cpu_addr_i  = a;
        cpu_wdata_i = wd;
        cpu_rd_i    = (op == 2'd0);
        cpu_wr_i    = (op == 2'd1);
        cpu_flush_i = (op == 2'd2);
        cpu_inv_i   = (op == 2'd3);
    endtask

    task automatic idle_in();
        cpu_rd_i = 0; cpu_wr_i = 0; cpu_flush_i = 0; cpu_inv_i = 0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [11:0] a, input logic [31:0] wd,
                          input logic [31:0] ed, input bit chk, input bit fast, input string req);
        int cyc;
        @(negedge clk);
        drive(op, a, wd);
        cyc = 0;
        while (!cpu_ready_o && cyc < 50) begin @(negedge clk); cyc++; end
        @(negedge clk);
        idle_in();
        cyc = 0;
        while (!cpu_valid_o && cyc < 50) begin @(negedge clk); cyc++; end
        check(cpu_valid_o, req, "valid returned", {31'h0, cpu_valid_o}, 32'h1);
        check(cpu_addr_o == a, req, "address echo", {20'h0, cpu_addr_o}, {20'h0, a});
        if (chk) check(cpu_rdata_o == ed, req, "data", cpu_rdata_o, ed);
        check((cyc == 0) == fast, req, "one-cycle completion", cyc, fast ? 0 : 1);
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [31:0] ed;
        logic        chk;
        logic        fast;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{2'd0, 12'h000, 32'h0,         32'hA000_0000, 1'b1, 1'b0},  // R3 read miss
        '{2'd0, 12'h001, 32'h0,         32'hA000_0001, 1'b1, 1'b1},  // R1 hit other word
        '{2'd1, 12'h000, 32'h1111_1111, 32'h1111_1111, 1'b1, 1'b1},  // R4 write hit
        '{2'd0, 12'h008, 32'h0,         32'hA000_0008, 1'b1, 1'b0},  // R8 fill invalid way
        '{2'd0, 12'h000, 32'h0,         32'h1111_1111, 1'b1, 1'b1},  // R1 hit, 0x008 now oldest
        '{2'd0, 12'h010, 32'h0,         32'hA000_0010, 1'b1, 1'b0},  // R8 evicts clean 0x008
        '{2'd0, 12'h008, 32'h0,         32'hA000_0008, 1'b1, 1'b0},  // R5 evicts dirty 0x000
        '{2'd0, 12'h000, 32'h0,         32'h1111_1111, 1'b1, 1'b0},  // R5 data survived
        '{2'd1, 12'h00A, 32'h2222_2222, 32'h2222_2222, 1'b1, 1'b0},  // R4 write miss
        '{2'd0, 12'h00A, 32'h0,         32'h2222_2222, 1'b1, 1'b1},  // R4 merged
        '{2'd2, 12'h00A, 32'h0,         32'h0,         1'b0, 1'b0},  // R6 dirty flush
        '{2'd0, 12'h00A, 32'h0,         32'h2222_2222, 1'b1, 1'b0},  // R6 line gone
        '{2'd1, 12'h00A, 32'h3333_3333, 32'h3333_3333, 1'b1, 1'b1},  // R7 dirty again
        '{2'd3, 12'h00A, 32'h0,         32'h0,         1'b0, 1'b1},  // R7 invalidate
        '{2'd0, 12'h00A, 32'h0,         32'h2222_2222, 1'b1, 1'b0}   // R7 dirty data lost
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_ready_o, "R10", "ready after reset", {31'h0, cpu_ready_o}, 32'h1);
        check(!cpu_valid_o, "R10", "valid after reset", {31'h0, cpu_valid_o}, 32'h0);
        check(mem_msg_o == 4'h0, "R10", "message after reset", {28'h0, mem_msg_o}, 32'h0);

        for (int i = 0; i < 15; i++) begin
            int n0;
            n0 = log_n;
            run_op(VECS[i].op, VECS[i].addr, VECS[i].wd, VECS[i].ed,
                   VECS[i].chk, VECS[i].fast, $sformatf("row%0d", i));
            case (i)
                0: begin
                    check(log_n == n0 + 1 && msg_log[n0] == 4'h1, "R3", "line read issued",
                          log_n - n0, 1);
                    check(last_rd_addr == 12'h000, "R3", "read address",
                          {20'h0, last_rd_addr}, 32'h0);
                end
                2: check(log_n == n0, "R4", "write hit no traffic", log_n - n0, 0);
                5: check(log_n == n0 + 1 && msg_log[n0] == 4'h1, "R8", "clean LRU victim",
                         log_n - n0, 1);
                6: begin
                    check(log_n == n0 + 2 && msg_log[n0] == 4'h2 && msg_log[n0+1] == 4'h1,
                          "R5", "write-back before read", log_n - n0, 2);
                    check(last_wb_addr == 12'h000, "R8", "LRU victim address",
                          {20'h0, last_wb_addr}, 32'h0);
                    check(last_wb_line[31:0] == 32'h1111_1111, "R5", "victim line",
                          last_wb_line[31:0], 32'h1111_1111);
                end
                10: begin
                    check(log_n == n0 + 1 && msg_log[n0] == 4'h3, "R6", "flush message",
                          log_n - n0, 1);
                    check(last_wb_addr == 12'h00A && last_wb_line[31:0] == 32'h2222_2222,
                          "R6", "flush line", last_wb_line[31:0], 32'h2222_2222);
                end
                13: check(log_n == n0, "R7", "invalidate no traffic", log_n - n0, 0);
                default: ;
            endcase
        end

        // R2: back-to-back hits, two requests in flight
        @(negedge clk);
        drive(2'd0, 12'h000, 32'h0);
        @(negedge clk);
        check(cpu_valid_o && cpu_ready_o, "R2", "first result with ready",
              {30'h0, cpu_valid_o, cpu_ready_o}, 32'h3);
        check(cpu_rdata_o == 32'h1111_1111, "R2", "first data", cpu_rdata_o, 32'h1111_1111);
        drive(2'd0, 12'h009, 32'h0);
        @(negedge clk);
        idle_in();
        check(cpu_valid_o && cpu_addr_o == 12'h009, "R2", "second result next cycle",
              {20'h0, cpu_addr_o}, 32'h009);
        check(cpu_rdata_o == 32'hA000_0009, "R2", "second data", cpu_rdata_o, 32'hA000_0009);

        // R9: write beats read; invalidate beats write
        @(negedge clk);
        drive(2'd1, 12'h000, 32'h4444_4444);
        cpu_rd_i = 1'b1;
        @(negedge clk);
        idle_in();
        check(cpu_valid_o && cpu_rdata_o == 32'h4444_4444, "R9", "write over read",
              cpu_rdata_o, 32'h4444_4444);
        run_op(2'd0, 12'h000, 32'h0, 32'h4444_4444, 1'b1, 1'b1, "R9");
        @(negedge clk);
        drive(2'd3, 12'h009, 32'h5555_5555);
        cpu_wr_i = 1'b1;
        @(negedge clk);
        idle_in();
        run_op(2'd0, 12'h009, 32'h0, 32'hA000_0009, 1'b1, 1'b0, "R9");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule